// File: doc/BRIEF.md
# Bit-band alias bus bridge

This bridge sits on the slave side of a 32-bit memory bus. It claims two alias windows, each 32 MiB long. Every 32-bit word in a window stands for one bit of a target region. The window whose address bits [31:25] equal 0x11 (base 0x2200_0000) maps onto the region based at 0x2000_0000. The window with bits [31:25] equal 0x21 (base 0x4200_0000) maps onto the region based at 0x4000_0000.

An alias read fetches the target unit from memory and returns only the selected bit. An alias write performs a locked read-modify-write on the target, so that only the selected bit changes. Requests arrive on a valid/ready port from the CPU. The bridge drives a request/response master port toward memory.

The bridge handles one transaction at a time. The memory answers every accepted request with a single-cycle `mem_resp` pulse, at least one cycle after the request handshake. That pulse carries `mem_rdata` and `mem_err`. Memory data uses little-endian byte lanes on a word-wide bus.

Top module: `bitband_bridge`

## Requirements
- R1: The bridge claims a request only when `cpu_addr[31:25]` is 0x11 or 0x21. For any other address, `cpu_hit` and `cpu_ready` stay low and no memory request is issued.
- R2: The memory address is the window's region base OR'd with alias offset bits [24:5]. It is then aligned down to 2 bytes for a halfword or 4 bytes for a word. `mem_size` carries the access size. Size codes are 0 = byte, 1 = halfword, 2 = word, and code 3 is treated as word.
- R3: The bit number n is offset bits [4:2] for a byte, [5:2] for a halfword and [6:2] for a word. Because the lanes are little-endian, that bit lies at `mem_rdata`/`mem_wdata` bit 8*target[1:0]+n.
- R4: An alias read issues exactly one memory read and no write. It returns the selected bit in `cpu_rdata[0]`, and bits [31:1] are zero.
- R5: An alias write reads the target unit and then writes it back to the same address with the same size. Only the selected bit changes, and it takes the value of `cpu_wdata[0]`. `cpu_wdata[31:1]` has no effect.
- R6: `mem_lock` is high from the read request of an alias write until that write's final memory response. It is low during alias reads and in the cycle `cpu_resp` is high.
- R7: `cpu_ready` is low from the cycle after a request is accepted until the cycle in which its response is given.
- R8: A memory error on the read phase ends the transaction with `cpu_err` high, read data zero and no write-back. A memory error on the write-back phase sets `cpu_err`.
- R9: Once `mem_valid` is raised, it stays high with `mem_addr`, `mem_write`, `mem_size` and `mem_wdata` unchanged until a cycle with `mem_ready` high.
- R10: `cpu_resp` is a single-cycle pulse, one cycle after the final memory response of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_ready | output | 1 | Request accepted this cycle (idle and claimed) |
| cpu_hit | output | 1 | Address lies in an alias window |
| cpu_addr | input | 32 | Alias address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_wdata | input | 32 | Write data; only bit 0 used |
| cpu_resp | output | 1 | Response pulse |
| cpu_rdata | output | 32 | Selected bit in bit 0 |
| cpu_err | output | 1 | Error, valid with cpu_resp |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request |
| mem_addr | output | 32 | Target byte address |
| mem_write | output | 1 | 1 = write-back phase |
| mem_size | output | 2 | Access size toward memory |
| mem_wdata | output | 32 | Merged word, lane-placed |
| mem_lock | output | 1 | Read and write-back must stay atomic |
| mem_resp | input | 1 | Memory response pulse |
| mem_rdata | input | 32 | Read data, lane-placed |
| mem_err | input | 1 | Memory error with mem_resp |

## Verification
The assertions rely on the memory keeping its side of the protocol. It gives one `mem_resp` per accepted request, never in the handshake cycle, and never while no request is outstanding. They also rely on the two configured windows not overlapping. The bench's memory model only answers after its own `mem_ready` handshake, with a latency of one to three cycles, so no stray or early response can occur. The CPU driver raises `cpu_valid` only between transactions. The random addresses stay inside the two default windows, with offsets small enough to land in the model's storage.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int NWIN = 2;
  localparam int BIT_SHIFT = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WB_REQ, ST_WB_WAIT
  } bb_state_e;

  // Size code 3 is folded onto word.
  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction

  function automatic logic [31:0] unit_align(input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return a;
      2'd1:    return {a[31:1], 1'b0};
      default: return {a[31:2], 2'b00};
    endcase
  endfunction

  // Position of the addressed bit on the little-endian 32-bit data bus.
  function automatic logic [4:0] bus_bit(input logic [31:0] tgt, input logic [31:0] al,
                                         input logic [1:0] sz);
    case (sz)
      2'd0:    return {tgt[1:0], al[4:2]};
      2'd1:    return {tgt[1], al[5:2]};
      default: return al[6:2];
    endcase
  endfunction

  function automatic logic [31:0] put_bit(input logic [31:0] w, input logic [4:0] pos,
                                          input logic v);
    logic [31:0] r;
    r = w;
    r[pos] = v;
    return r;
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int WIN_LSB = 25,
  parameter logic [NWIN-1:0][31:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN-1:0][31:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [31:0]     addr,
  input  logic [1:0]      size,
  output logic [NWIN-1:0] win_hit,
  output logic            hit,
  output logic [31:0]     tgt,
  output logic [4:0]      pos,
  output logic [1:0]      nsize
);
  localparam int TOP_W = 32 - WIN_LSB;

  logic [31:0] offs, base_sel, raw;

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      assign win_hit[g] = (addr[31:WIN_LSB] == ALIAS_BASE[g][31:WIN_LSB]);
    end
  endgenerate

  assign hit = |win_hit;

  always_comb begin
    base_sel = '0;
    for (int i = 0; i < NWIN; i++)
      if (win_hit[i]) base_sel = base_sel | REGION_BASE[i];
    offs  = {{TOP_W{1'b0}}, addr[WIN_LSB-1:0]};
    raw   = base_sel | (offs >> BIT_SHIFT);
    nsize = norm_size(size);
    tgt   = unit_align(raw, nsize);
    pos   = bus_bit(tgt, addr, nsize);
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_wr,
  input  logic [31:0] start_addr,
  input  logic [1:0]  start_size,
  input  logic [4:0]  start_pos,
  input  logic        start_bit,
  output logic        idle,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  output logic        mem_write,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  output logic        mem_lock,
  input  logic        mem_resp,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        cpu_resp,
  output logic [31:0] cpu_rdata,
  output logic        cpu_err
);
  bb_state_e   state;
  logic        op_wr_q, bit_q, rbit_q;
  logic [31:0] addr_q, wb_word_q, rd_raw_q;
  logic [1:0]  size_q;
  logic [4:0]  pos_q;

  // Named events for the checks below.
  logic rd_done_evt, rd_fail_evt, wb_done_evt;
  assign rd_done_evt = (state == ST_RD_WAIT) && mem_resp;
  assign rd_fail_evt = rd_done_evt && op_wr_q && mem_err;
  assign wb_done_evt = (state == ST_WB_WAIT) && mem_resp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_wr_q   <= 1'b0;
      bit_q     <= 1'b0;
      rbit_q    <= 1'b0;
      addr_q    <= '0;
      size_q    <= '0;
      pos_q     <= '0;
      wb_word_q <= '0;
      rd_raw_q  <= '0;
      cpu_resp  <= 1'b0;
      cpu_err   <= 1'b0;
    end else begin
      cpu_resp <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_wr_q <= start_wr;
          addr_q  <= start_addr;
          size_q  <= start_size;
          pos_q   <= start_pos;
          bit_q   <= start_bit;
          state   <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_resp) begin
          rd_raw_q <= mem_rdata;
          if (!op_wr_q || mem_err) begin
            cpu_resp <= 1'b1;
            cpu_err  <= mem_err;
            rbit_q   <= op_wr_q ? 1'b0 : (mem_rdata[pos_q] & ~mem_err);
            state    <= ST_IDLE;
          end else begin
            wb_word_q <= put_bit(mem_rdata, pos_q, bit_q);
            state     <= ST_WB_REQ;
          end
        end
        ST_WB_REQ: if (mem_ready) state <= ST_WB_WAIT;
        ST_WB_WAIT: if (mem_resp) begin
          cpu_resp <= 1'b1;
          cpu_err  <= mem_err;
          rbit_q   <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign mem_valid = (state == ST_RD_REQ) || (state == ST_WB_REQ);
  assign mem_write = (state == ST_WB_REQ);
  assign mem_addr  = addr_q;
  assign mem_size  = size_q;
  assign mem_wdata = wb_word_q;
  assign mem_lock  = op_wr_q && (state != ST_IDLE);
  assign cpu_rdata = {31'b0, rbit_q};

  // R6
  wb_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> mem_lock);
  // R6
  resp_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp |-> !mem_lock);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_wdata));
  // R5
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> $countones(mem_wdata ^ rd_raw_q) <= 1);
  // R8
  no_wb_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fail_evt |=> !mem_valid && cpu_resp && cpu_err);
  // R10
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done_evt |=> cpu_resp);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int WIN_LSB = 25,
  parameter logic [NWIN-1:0][31:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN-1:0][31:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  output logic        cpu_ready,
  output logic        cpu_hit,
  input  logic [31:0] cpu_addr,
  input  logic        cpu_write,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_resp,
  output logic [31:0] cpu_rdata,
  output logic        cpu_err,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  output logic        mem_write,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  output logic        mem_lock,
  input  logic        mem_resp,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);
  logic [NWIN-1:0] win_hit;
  logic [31:0]     tgt;
  logic [4:0]      pos;
  logic [1:0]      nsize;
  logic            idle, accept;
  logic            unused_wdata;

  assign unused_wdata = ^cpu_wdata[31:1];

  bb_decode #(
    .WIN_LSB(WIN_LSB), .ALIAS_BASE(ALIAS_BASE), .REGION_BASE(REGION_BASE)
  ) u_dec (
    .addr(cpu_addr), .size(cpu_size), .win_hit(win_hit), .hit(cpu_hit),
    .tgt(tgt), .pos(pos), .nsize(nsize)
  );

  assign cpu_ready = idle && cpu_hit;
  assign accept    = cpu_valid && cpu_ready;

  bb_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept), .start_wr(cpu_write), .start_addr(tgt), .start_size(nsize),
    .start_pos(pos), .start_bit(cpu_wdata[0]), .idle(idle),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_lock(mem_lock), .mem_resp(mem_resp), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err)
  );

  // R1
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit));
  // R7
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid && !mem_lock);
  // R7
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cpu_ready);
endmodule

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [1:0]  cpu_size = '0;
  logic        cpu_ready, cpu_hit, cpu_resp, cpu_err;
  logic [31:0] cpu_rdata;
  logic        mem_valid, mem_write, mem_lock;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ready = 1'b0, mem_resp = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  bitband_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_hit(cpu_hit), .cpu_addr(cpu_addr), .cpu_write(cpu_write), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_lock(mem_lock), .mem_resp(mem_resp), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [128];
  logic [31:0] ref_mem [128];
  int rd_cnt = 0, wr_cnt = 0, hold_bad = 0;
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [1:0]  last_rd_size, last_wr_size;
  logic        last_rd_lock, last_wr_lock;
  bit inj_rd_err = 0, inj_wr_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [31:0] a);
    return {25'd0, a[30], a[7:2]};
  endfunction

  // Expected target and bus bit, derived arithmetically.
  function automatic int unsigned e_size(input logic [1:0] sz);
    return (sz > 2) ? 2 : sz;
  endfunction
  function automatic int unsigned e_tgt(input int unsigned a, input logic [1:0] sz);
    int unsigned base, al, t, nb;
    base = (a >= 32'h4200_0000) ? 32'h4000_0000 : 32'h2000_0000;
    al   = base + 32'h0200_0000;
    t    = base + (a - al) / 32;
    nb   = 1 << e_size(sz);
    return t - (t % nb);
  endfunction
  function automatic int unsigned e_pos(input int unsigned a, input logic [1:0] sz);
    int unsigned al, n;
    al = (a >= 32'h4200_0000) ? 32'h4200_0000 : 32'h2200_0000;
    n  = ((a - al) / 4) % (8 << e_size(sz));
    return (e_tgt(a, sz) % 4) * 8 + n;
  endfunction

  // Memory model: random ready delay, 1..3 cycle response latency.
  initial begin
    logic [31:0] a, d;
    logic        w, e;
    logic [1:0]  s;
    forever begin
      @(negedge clk);
      mem_resp = 1'b0;
      mem_err  = 1'b0;
      if (rst_n && mem_valid) begin
        a = mem_addr; w = mem_write; d = mem_wdata; s = mem_size;
        repeat ($urandom % 3) begin
          @(negedge clk);
          if (!mem_valid || mem_addr != a || mem_write != w) hold_bad++;
        end
        if (w) begin last_wr_addr = a; last_wr_size = s; last_wr_lock = mem_lock; end
        else   begin last_rd_addr = a; last_rd_size = s; last_rd_lock = mem_lock; end
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        if (w) begin
          wr_cnt++;
          e = inj_wr_err; inj_wr_err = 0;
          if (!e)
            for (int l = 0; l < 4; l++)
              if (s >= 2 || (s == 1 && (l / 2) == a[1]) || (s == 0 && l == a[1:0]))
                mem[idx_of(a)][l*8 +: 8] = d[l*8 +: 8];
          mem_rdata = '0;
        end else begin
          rd_cnt++;
          e = inj_rd_err; inj_rd_err = 0;
          mem_rdata = mem[idx_of(a)];
        end
        mem_err  = e;
        mem_resp = 1'b1;
      end
    end
  end

  task automatic xfer(input logic [31:0] a, input logic w, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er);
    int guard;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_write = w; cpu_size = sz; cpu_wdata = wd;
    #1;
    guard = 0;
    while (!cpu_ready && guard < 50) begin @(negedge clk); #1; guard++; end
    @(negedge clk);
    cpu_valid = 1'b0;
    chk(!cpu_ready, "R7", cpu_ready, 0);
    guard = 0;
    while (!cpu_resp && guard < 50) begin @(negedge clk); guard++; end
    rd = cpu_rdata; er = cpu_err;
    chk(!mem_lock, "R6", mem_lock, 0);
    @(negedge clk);
    chk(!cpu_resp, "R10", cpu_resp, 0);
  endtask

  task automatic run_one(input logic [31:0] a, input logic w, input logic [1:0] sz,
                         input logic [31:0] wd);
    logic [31:0] rd;
    logic er;
    int r0, w0, ix;
    int unsigned t, p;
    t = e_tgt(a, sz); p = e_pos(a, sz); ix = idx_of(t);
    r0 = rd_cnt; w0 = wr_cnt;
    xfer(a, w, sz, wd, rd, er);
    chk(er == 0, "R8", er, 0);
    chk(last_rd_addr == t, "R2", last_rd_addr, t);
    chk(last_rd_size == e_size(sz), "R2", last_rd_size, e_size(sz));
    chk(rd_cnt == r0 + 1, "R4", rd_cnt, r0 + 1);
    if (!w) begin
      chk(rd == {31'b0, ref_mem[ix][p]}, "R4", rd, ref_mem[ix][p]);
      chk(wr_cnt == w0, "R4", wr_cnt, w0);
      chk(last_rd_lock == 0, "R6", last_rd_lock, 0);
    end else begin
      ref_mem[ix][p] = wd[0];
      chk(wr_cnt == w0 + 1, "R5", wr_cnt, w0 + 1);
      chk(last_wr_addr == t, "R5", last_wr_addr, t);
      chk(last_rd_lock && last_wr_lock, "R6", {last_rd_lock, last_wr_lock}, 2'b11);
      chk(mem[ix] == ref_mem[ix], "R3", mem[ix], ref_mem[ix]);
    end
  endtask

  task automatic try_outside(input logic [31:0] a);
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_write = 1'b0; cpu_size = 2'd2;
    repeat (4) @(negedge clk);
    chk(!cpu_hit && !cpu_ready, "R1", {cpu_hit, cpu_ready}, 0);
    chk(!mem_valid && rd_cnt == r0, "R1", rd_cnt, r0);
    cpu_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] rd, a;
    logic er;
    int r0, w0;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 128; i++) begin mem[i] = $urandom; ref_mem[i] = mem[i]; end
    repeat (3) @(negedge clk);
    // Reset state
    chk(!mem_valid && !mem_lock && !cpu_resp, "R7", {mem_valid, mem_lock, cpu_resp}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outside both windows
    try_outside(32'h2000_0100);
    try_outside(32'h21FF_FFFC);
    try_outside(32'h4400_0000);
    try_outside(32'h6200_0000);

    // R3 directed lane corners
    run_one(32'h2200_007C, 1'b1, 2'd2, 32'h1);          // word bit 31
    run_one(32'h2200_007C, 1'b0, 2'd2, 32'h0);
    run_one(32'h2200_007C, 1'b1, 2'd1, 32'hFFFF_FFFE);  // halfword, clears bit 31 lane 3
    run_one(32'h2200_007C, 1'b0, 2'd1, 32'h0);
    run_one(32'h4200_0060, 1'b1, 2'd0, 32'h1);          // byte lane 3 bit 0
    run_one(32'h4200_0060, 1'b0, 2'd0, 32'h0);
    run_one(32'h4200_0000, 1'b1, 2'd3, 32'hFFFF_FFFE);  // size 3 as word, R5 other bits ignored
    run_one(32'h4200_0000, 1'b0, 2'd3, 32'h0);

    // R8: read-phase error on a write
    a = 32'h2200_0124;
    r0 = rd_cnt; w0 = wr_cnt;
    inj_rd_err = 1;
    xfer(a, 1'b1, 2'd2, 32'h1, rd, er);
    chk(er == 1, "R8", er, 1);
    chk(wr_cnt == w0 && rd_cnt == r0 + 1, "R8", wr_cnt, w0);
    chk(mem[idx_of(e_tgt(a, 2))] == ref_mem[idx_of(e_tgt(a, 2))], "R8",
        mem[idx_of(e_tgt(a, 2))], ref_mem[idx_of(e_tgt(a, 2))]);
    // R8: read error on a read gives zero data
    inj_rd_err = 1;
    xfer(a, 1'b0, 2'd0, 32'h0, rd, er);
    chk(er == 1 && rd == 0, "R8", {er, rd}, 33'h1_0000_0000);
    // R8: write-back error
    w0 = wr_cnt;
    inj_wr_err = 1;
    xfer(a, 1'b1, 2'd1, 32'h1, rd, er);
    chk(er == 1 && wr_cnt == w0 + 1, "R8", er, 1);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra;
      ra = (($urandom % 2) ? 32'h4200_0000 : 32'h2200_0000) + ($urandom % 32'h2000);
      run_one(ra, $urandom % 2, $urandom % 4, $urandom);
    end

    chk(hold_bad == 0, "R9", hold_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule